// File: doc/BRIEF.md
# Warp Global Memory Coalescer

The block turns one warp-wide global or local memory instruction into a short list of aligned memory segment requests. For each of the 32 lanes it receives a byte address, plus an active mask for the whole warp, the access width in bytes and a flag that marks atomic operations. The segment size follows from the access width. Each active lane is mapped onto an aligned segment.

Lanes that fall in the same segment are folded into one request, but only when they sit in the same half of the warp and the instruction is not atomic. Each request records which quarters of its segment are touched. Before it leaves the block, a request is narrowed to the smallest aligned half or quarter that still covers every touched quarter.

A warp is accepted with a valid/ready handshake. The block then scans its lanes, one per clock, into an internal table. After the scan it hands out the requests in the order they were created, one per cycle, over a valid/ready output. The last request of the warp is tagged.

Top module: `warp_coalescer`

## Requirements
- R1: The segment is 32 bytes for 1-byte accesses, 64 bytes for 2-byte accesses and 128 bytes for 4-, 8- or 16-byte accesses. `out_size` encodes the emitted size as 0 = 32 bytes, 1 = 64 bytes, 2 = 128 bytes, and never takes the value 3.
- R2: Before narrowing, a request's base is the lane address with the low log2(segment size) bits cleared. Every emitted `out_addr` is aligned to the emitted size.
- R3: A non-atomic active lane joins an earlier request of the same warp half (lanes 0-15 or lanes 16-31) that has the same segment base. The lane's bit is set in that request's `out_lanes` (bit i = lane i). A lane never joins a request created in the other half.
- R4: For an atomic warp, every active lane produces its own request, with exactly one bit set in `out_lanes`.
- R5: Inactive lanes produce no request. A warp with no active lane produces no output, and `in_ready` returns high after the scan.
- R6: Quarter q of a segment of S bytes is (address / (S/4)) mod 4. A 128-byte request that touches only quarters {0,1}, or only quarters {2,3}, becomes 64 bytes. Its base is raised by 64 when the upper pair was the one touched.
- R7: A 64-byte request becomes 32 bytes when only one of its two halves is touched. After an R6 narrowing, the two halves are quarters {0,2} versus {1,3}. Otherwise they are quarters {0,1} versus {2,3}. The base is raised by 32 when the upper half was the one touched.
- R8: Requests leave in creation order: the first half's requests come before the second half's, and within a half they follow the order of first use. `out_last` marks the final request of the warp.
- R9: An access width other than 1, 2, 4, 8 or 16 raises `bad_size` in the cycle the warp is offered. Such a warp is consumed and produces no request.
- R10: `in_ready` is low from the cycle after a valid warp is accepted until the cycle after its final request is taken.
- R11: While `out_valid` is high and `out_ready` is low, the output request stays unchanged.
- R12: After reset, `in_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A warp instruction is offered |
| in_ready | output | 1 | The block can take a warp |
| in_addr | input | 1024 | Lane byte addresses, lane i in bits [32i+31:32i] |
| in_active | input | 32 | Active-lane mask |
| in_dsize | input | 5 | Access width in bytes |
| in_atomic | input | 1 | The instruction is atomic |
| bad_size | output | 1 | The offered access width is illegal |
| out_valid | output | 1 | A segment request is presented |
| out_ready | input | 1 | Downstream takes the request |
| out_addr | output | 32 | Request base address |
| out_size | output | 2 | Request size code |
| out_lanes | output | 32 | Lanes served by the request |
| out_last | output | 1 | Final request of the warp |

## Verification
The checker watches properties that hold on every cycle. An emitted size code is legal and its base is aligned. A request never has an empty lane mask, and under an atomic warp it serves exactly one lane. The output holds still while stalled. The block never offers a request while it is ready for a new warp, and it goes quiet after the last request is taken. What only the bench's scenarios can show is whether the lanes were grouped correctly: the half-warp boundary, the quarter-based narrowing in both orders, and the exact base, size and order of each request. The bench compares all of these against its behavioural model for fixed and randomized warps.

// File: rtl/wc_pkg.sv
package wc_pkg;

    localparam int unsigned WC_LANES = 32;
    localparam int unsigned WC_AW    = 32;
    localparam int unsigned WC_HALF  = WC_LANES / 2;
    localparam int unsigned WC_LW    = $clog2(WC_LANES);
    localparam int unsigned WC_CW    = WC_LW + 1;

    typedef logic [WC_AW-1:0]    addr_t;
    typedef logic [WC_LANES-1:0] lmask_t;
    typedef logic [WC_CW-1:0]    cnt_t;
    typedef logic [WC_LW-1:0]    lane_t;

    typedef enum logic [1:0] {
        SEG32  = 2'd0,
        SEG64  = 2'd1,
        SEG128 = 2'd2
    } seg_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_EMIT = 2'd2
    } state_e;

    typedef struct packed {
        addr_t      base;
        lmask_t     lanes;
        logic [3:0] quarters;
    } entry_t;

    typedef struct packed {
        addr_t base;
        seg_e  size;
    } req_t;

    function automatic logic size_ok(input logic [4:0] dsize);
        case (dsize)
            5'd1, 5'd2, 5'd4, 5'd8, 5'd16: return 1'b1;
            default:                       return 1'b0;
        endcase
    endfunction

    function automatic seg_e seg_of(input logic [4:0] dsize);
        case (dsize)
            5'd1:    return SEG32;
            5'd2:    return SEG64;
            default: return SEG128;
        endcase
    endfunction

    function automatic addr_t seg_base(input addr_t a, input seg_e s);
        return a & ~((addr_t'(32) << s) - addr_t'(1));
    endfunction

    function automatic logic [1:0] quarter_of(input addr_t a, input seg_e s);
        case (s)
            SEG32:   return a[4:3];
            SEG64:   return a[5:4];
            default: return a[6:5];
        endcase
    endfunction

    // Two-step narrowing: 128 -> 64 on quarter pairs {0,1}/{2,3},
    // then 64 -> 32 on {0,2}/{1,3} after a first step, else {0,1}/{2,3}.
    function automatic req_t shrink_req(input addr_t base, input seg_e s,
                                        input logic [3:0] q);
        req_t r;
        logic lo, hi;
        r.base = base;
        r.size = s;
        lo = q[0] | q[1];
        hi = q[2] | q[3];
        if (s == SEG128 && (lo ^ hi)) begin
            r.size = SEG64;
            if (hi) r.base = r.base + addr_t'(64);
            lo = q[0] | q[2];
            hi = q[1] | q[3];
        end
        if (r.size == SEG64 && (lo ^ hi)) begin
            r.size = SEG32;
            if (hi) r.base = r.base + addr_t'(32);
        end
        return r;
    endfunction

endpackage

// File: rtl/wc_lane_table.sv
module wc_lane_table
    import wc_pkg::*;
#(
    parameter int unsigned DEPTH = WC_LANES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       wr_en,
    input  addr_t      wr_base,
    input  logic [1:0] wr_quarter,
    input  lane_t      wr_lane,
    input  logic       no_merge,
    input  cnt_t       half_base,
    input  cnt_t       rd_idx,
    output cnt_t       count,
    output cnt_t       count_after,
    output entry_t     rd_entry
);

    entry_t           tbl [DEPTH];
    logic [DEPTH-1:0] hit_vec;
    logic             any_hit;
    lmask_t           lane_bit;
    logic [3:0]       quarter_bit;

    assign lane_bit    = lmask_t'(1) << wr_lane;
    assign quarter_bit = 4'b0001 << wr_quarter;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            assign hit_vec[i] = !no_merge
                             && (cnt_t'(i) >= half_base)
                             && (cnt_t'(i) <  count)
                             && (tbl[i].base == wr_base);

            always_ff @(posedge clk) begin
                if (wr_en && hit_vec[i]) begin
                    tbl[i].lanes    <= tbl[i].lanes | lane_bit;
                    tbl[i].quarters <= tbl[i].quarters | quarter_bit;
                end else if (wr_en && !any_hit && count == cnt_t'(i)) begin
                    tbl[i] <= '{base: wr_base, lanes: lane_bit, quarters: quarter_bit};
                end
            end
        end
    endgenerate

    assign any_hit     = |hit_vec;
    assign count_after = count + cnt_t'(wr_en && !any_hit);
    assign rd_entry    = tbl[rd_idx[WC_LW-1:0]];

    always_ff @(posedge clk) begin
        if (rst || clear) count <= '0;
        else              count <= count_after;
    end

endmodule

// File: rtl/wc_trim.sv
module wc_trim
    import wc_pkg::*;
(
    input  entry_t ent,
    input  seg_e   seg,
    output req_t   req
);

    assign req = shrink_req(ent.base, seg, ent.quarters);

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import wc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [WC_LANES*WC_AW-1:0] in_addr,
    input  logic [WC_LANES-1:0]       in_active,
    input  logic [4:0]                in_dsize,
    input  logic                      in_atomic,
    output logic                      bad_size,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [WC_AW-1:0]          out_addr,
    output logic [1:0]                out_size,
    output logic [WC_LANES-1:0]       out_lanes,
    output logic                      out_last
);

    state_e state;
    addr_t  addr_q [WC_LANES];
    lmask_t act_q;
    seg_e   seg_q;
    logic   atom_q;
    lane_t  lane;
    cnt_t   half_base;
    cnt_t   rd;

    logic   accept;
    addr_t  cur_addr;
    logic   wr_en;
    cnt_t   count;
    cnt_t   count_after;
    entry_t rd_entry;
    req_t   req;

    assign in_ready = (state == ST_IDLE);
    assign bad_size = in_ready && in_valid && !size_ok(in_dsize);
    assign accept   = in_ready && in_valid && size_ok(in_dsize);
    assign cur_addr = addr_q[lane];
    assign wr_en    = (state == ST_SCAN) && act_q[lane];

    wc_lane_table #(.DEPTH(WC_LANES)) u_table (
        .clk         (clk),
        .rst         (rst),
        .clear       (accept),
        .wr_en       (wr_en),
        .wr_base     (seg_base(cur_addr, seg_q)),
        .wr_quarter  (quarter_of(cur_addr, seg_q)),
        .wr_lane     (lane),
        .no_merge    (atom_q),
        .half_base   (half_base),
        .rd_idx      (rd),
        .count       (count),
        .count_after (count_after),
        .rd_entry    (rd_entry)
    );

    wc_trim u_trim (
        .ent (rd_entry),
        .seg (seg_q),
        .req (req)
    );

    always_ff @(posedge clk) begin
        if (accept) begin
            for (int l = 0; l < WC_LANES; l++) begin
                addr_q[l] <= in_addr[l*WC_AW +: WC_AW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            act_q     <= '0;
            seg_q     <= SEG32;
            atom_q    <= 1'b0;
            lane      <= '0;
            half_base <= '0;
            rd        <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state     <= ST_SCAN;
                        act_q     <= in_active;
                        seg_q     <= seg_of(in_dsize);
                        atom_q    <= in_atomic;
                        lane      <= '0;
                        half_base <= '0;
                    end
                end
                ST_SCAN: begin
                    lane <= lane + lane_t'(1);
                    if (lane == lane_t'(WC_HALF - 1)) begin
                        half_base <= count_after;
                    end
                    if (lane == lane_t'(WC_LANES - 1)) begin
                        rd    <= '0;
                        state <= (count_after == '0) ? ST_IDLE : ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        if (out_last) state <= ST_IDLE;
                        else          rd    <= rd + cnt_t'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign out_valid = (state == ST_EMIT);
    assign out_addr  = req.base;
    assign out_size  = req.size;
    assign out_lanes = rd_entry.lanes;
    assign out_last  = (rd == cnt_t'(count - cnt_t'(1)));

endmodule

// File: rtl/wc_checker.sv
module wc_checker
    import wc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic               in_atomic,
    input logic               bad_size,
    input logic               out_valid,
    input logic               out_ready,
    input logic [WC_AW-1:0]   out_addr,
    input logic [1:0]         out_size,
    input logic [WC_LANES-1:0] out_lanes,
    input logic               out_last
);

    logic atom_seen;

    always_ff @(posedge clk) begin
        if (rst)                                   atom_seen <= 1'b0;
        else if (in_valid && in_ready && !bad_size) atom_seen <= in_atomic;
    end

    // R1
    size_code_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_size != 2'd3);

    // R2
    base_align_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_addr & ((addr_t'(32) << out_size) - addr_t'(1))) == '0);

    // R5
    lanes_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_lanes != '0);

    // R4
    atomic_single_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && atom_seen) |-> $countones(out_lanes) == 1);

    // R8
    last_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid);

    // R9
    bad_size_idle_chk: assert property (@(posedge clk) disable iff (rst)
        bad_size |=> (in_ready && !out_valid));

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
            && $stable(out_size) && $stable(out_lanes) && $stable(out_last)));

endmodule

bind warp_coalescer wc_checker u_wc_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_atomic (in_atomic),
    .bad_size  (bad_size),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_size  (out_size),
    .out_lanes (out_lanes),
    .out_last  (out_last)
);

// File: tb/warp_coalescer_bench.sv
`timescale 1ns/1ps
module warp_coalescer_bench;
    import wc_pkg::*;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic                      in_valid = 1'b0;
    logic                      in_ready;
    logic [WC_LANES*WC_AW-1:0] in_addr = '0;
    logic [WC_LANES-1:0]       in_active = '0;
    logic [4:0]                in_dsize = 5'd4;
    logic                      in_atomic = 1'b0;
    logic                      bad_size;
    logic                      out_valid;
    logic                      out_ready = 1'b0;
    logic [WC_AW-1:0]          out_addr;
    logic [1:0]                out_size;
    logic [WC_LANES-1:0]       out_lanes;
    logic                      out_last;

    warp_coalescer u_warp_coalescer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_active(in_active), .in_dsize(in_dsize),
        .in_atomic(in_atomic), .bad_size(bad_size), .out_valid(out_valid),
        .out_ready(out_ready), .out_addr(out_addr), .out_size(out_size),
        .out_lanes(out_lanes), .out_last(out_last)
    );

    always #2 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit running = 1'b0;

    logic [31:0] q_addr[$];
    int          q_size[$];
    logic [31:0] q_lanes[$];
    bit          q_last[$];

    logic [31:0] wa [32];
    logic [31:0] wact;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Behavioural model of R1-R8: lists per half, then narrowing.
    task automatic model_warp(input int ds, input bit atom);
        logic [31:0] b[$];
        logic [31:0] m[$];
        int          qf[$];
        int          seg;
        int          first;
        first = q_addr.size();
        seg = (ds == 1) ? 32 : ((ds == 2) ? 64 : 128);
        for (int h = 0; h < 2; h++) begin
            b.delete(); m.delete(); qf.delete();
            for (int l = h*16; l < h*16 + 16; l++) begin
                if (wact[l]) begin
                    logic [31:0] sb;
                    int qq;
                    int hit;
                    sb  = wa[l] & ~(32'(seg) - 32'd1);
                    qq  = int'((wa[l] / 32'(seg / 4)) % 32'd4);
                    hit = -1;
                    if (!atom) begin
                        for (int k = 0; k < b.size(); k++) begin
                            if (hit < 0 && b[k] == sb) hit = k;
                        end
                    end
                    if (hit < 0) begin
                        b.push_back(sb);
                        m.push_back(32'd1 << l);
                        qf.push_back(1 << qq);
                    end else begin
                        m[hit]  = m[hit] | (32'd1 << l);
                        qf[hit] = qf[hit] | (1 << qq);
                    end
                end
            end
            for (int k = 0; k < b.size(); k++) begin
                int          sz;
                logic [31:0] base;
                bit          lo, hi;
                sz   = seg;
                base = b[k];
                lo = qf[k][0] | qf[k][1];
                hi = qf[k][2] | qf[k][3];
                if (sz == 128 && lo != hi) begin
                    sz = 64;
                    if (hi) base = base + 32'd64;
                    lo = qf[k][0] | qf[k][2];
                    hi = qf[k][1] | qf[k][3];
                end
                if (sz == 64 && lo != hi) begin
                    sz = 32;
                    if (hi) base = base + 32'd32;
                end
                q_addr.push_back(base);
                q_size.push_back(sz == 32 ? 0 : (sz == 64 ? 1 : 2));
                q_lanes.push_back(m[k]);
                q_last.push_back(1'b0);
            end
        end
        if (q_addr.size() > first) q_last[q_last.size()-1] = 1'b1;
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!rst && running) begin
            if (out_valid) begin
                if (q_addr.size() == 0) begin
                    check(1'b0, "R8", "request with none expected", out_addr, 0);
                end else begin
                    check(out_addr == q_addr[0], "R2/R6/R7", "base", out_addr, q_addr[0]);
                    check(int'(out_size) == q_size[0], "R1/R6/R7", "size code", out_size, q_size[0]);
                    check(out_lanes == q_lanes[0], "R3/R4", "lane mask", out_lanes, q_lanes[0]);
                    check(out_last == q_last[0], "R8", "last flag", out_last, q_last[0]);
                    check(!in_ready, "R10", "ready while emitting", in_ready, 0);
                end
            end
            out_ready = ($urandom % 4) != 0;
            if (out_valid && out_ready && q_addr.size() != 0) begin
                void'(q_addr.pop_front());
                void'(q_size.pop_front());
                void'(q_lanes.pop_front());
                void'(q_last.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            finish_run();
        end
    end

    task automatic send(input int ds, input bit atom);
        bit legal;
        legal = (ds == 1 || ds == 2 || ds == 4 || ds == 8 || ds == 16);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        if (legal) model_warp(ds, atom);
        for (int l = 0; l < 32; l++) in_addr[l*32 +: 32] = wa[l];
        in_active = wact;
        in_dsize  = 5'(ds);
        in_atomic = atom;
        in_valid  = 1'b1;
        #1;
        check(bad_size == !legal, "R9", "bad_size on offer", bad_size, !legal);
        @(negedge clk);
        in_valid = 1'b0;
        if (legal) begin
            check(!in_ready, "R10", "ready after accept", in_ready, 0);
        end else begin
            check(in_ready && !out_valid, "R9", "idle after illegal width",
                  {in_ready, out_valid}, 2'b10);
        end
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        @(negedge clk);
        while ((q_addr.size() != 0 || !in_ready) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check(q_addr.size() == 0, "R8", "pending requests after drain", q_addr.size(), 0);
    endtask

    task automatic stride(input logic [31:0] base, input int step);
        for (int l = 0; l < 32; l++) wa[l] = base + 32'(l * step);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12
        check(in_ready && !out_valid, "R12", "reset state", {in_ready, out_valid}, 2'b10);
        running = 1'b1;

        // R6: 4-byte stride, each half uses one 64-byte half of the segment
        stride(32'h1000, 4); wact = '1; send(4, 0); drain();
        // R1 / R3: 1-byte stride, both halves in one 32-byte segment, not merged
        stride(32'h2000, 1); wact = '1; send(1, 0); drain();
        // R7: 2-byte stride, 64-byte segments narrowed on {0,1}/{2,3}
        stride(32'h3000, 2); wact = '1; send(2, 0); drain();
        // R6 then R7: every lane on one word in quarter 3
        stride(32'h4074, 0); wact = '1; send(4, 0); drain();
        // R4: atomic with a sparse mask
        stride(32'h5000, 4); wact = 32'h0000F00F; send(4, 1); drain();
        // R5: mixed mask with 8-byte accesses
        stride(32'h6000, 8); wact = 32'hAAAA5555; send(8, 0); drain();
        // R1: 16-byte stride, full 128-byte segments stay whole
        stride(32'h7000, 16); wact = '1; send(16, 0); drain();
        // R9: illegal widths
        send(3, 0);
        send(12, 0);
        // R5: no active lanes
        stride(32'h8000, 4); wact = '0; send(4, 0);
        repeat (40) @(negedge clk);
        check(in_ready && !out_valid, "R5", "empty warp returns to idle",
              {in_ready, out_valid}, 2'b10);

        // Randomized warps over a small window to force merging
        for (int w = 0; w < 40; w++) begin
            int ds;
            bit atom;
            logic [31:0] base;
            case ($urandom % 5)
                0: ds = 1;
                1: ds = 2;
                2: ds = 4;
                3: ds = 8;
                default: ds = 16;
            endcase
            atom = ($urandom % 5) == 0;
            base = 32'h10000 + 32'(($urandom % 64) * 256);
            for (int l = 0; l < 32; l++) begin
                wa[l] = base + (32'($urandom % 512) & ~(32'(ds) - 32'd1));
            end
            wact = $urandom;
            send(ds, atom);
            drain();
        end

        running = 1'b0;
        finish_run();
    end

endmodule